// File: doc/BRIEF.md
# Four-Input Round-Robin Leaf Arbiter

This cell is the bottom level of a tree-shaped round-robin arbiter. It collects four request lines, asks its parent for service with a single upward request, and when the parent acknowledges it hands a one-hot grant to exactly one requester. Four fixed-priority encoders run side by side, each with a different rotation of the input order. A 2-bit state register picks which encoder result reaches the grant output. The state is loaded from the grant that was actually issued, so the input that was just served drops to the bottom of the order.

Each leaf keeps a record of the inputs it has served since its round began. Once every input that is currently requesting has been served, the leaf locks. A locked leaf withdraws its upward request and issues no grant, so the parent cannot update its own rotation until the other leaves have had their turn. The lock is released when the parent signals a new round, or when the leaf goes idle with no requests at all.

Top module: `arb_leaf`

## Requirements
- R1: After reset the state is 00, the lock flag is low and the served record is empty. In state 00 the priority order from highest to lowest is input 3, 2, 1, 0.
- R2: `grant_o` is one-hot or zero, only ever names an input whose request is high, and is zero in any cycle where `ack_i` is low.
- R3: In state s the highest-priority input is (s+3) mod 4, and priority falls with descending index, wrapping from 0 to 3. For example, in state 00 with only inputs 0 and 2 requesting, the grant is 4'b0100.
- R4: On a clock edge where a grant is issued, the state takes the index of the granted input, so the input with the next lower index becomes highest. Without a grant, the state holds. For example, after input 2 is granted the state is 10, and the order becomes 1, 0, 3, 2.
- R5: `up_req_o` is high exactly when at least one request is high and the lock flag is low.
- R6: The lock flag rises on the edge after a grant that leaves no requesting input unserved in the current round. While it is set, `grant_o` is zero and `up_req_o` is low, whatever `ack_i` is.
- R7: A high `round_start_i` clears both the lock flag and the served record on the next edge.
- R8: A cycle with all four requests low clears both the lock flag and the served record on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the cell |
| req_i | input | 4 | Request lines, one per input |
| ack_i | input | 1 | Acknowledge from the parent node for this leaf |
| round_start_i | input | 1 | Start of a new round, signalled by the parent |
| grant_o | output | 4 | One-hot grant |
| up_req_o | output | 1 | Request to the parent |
| lock_o | output | 1 | High once all current requesters have been served in this round |

## Verification
Sparse two-input patterns, such as inputs 0 and 2 alone, show whether the rotation skips idle inputs and lands on the next lower index rather than simply the next index. A single steady requester locks the leaf after one grant. Saturated requests sweep all four states in turn, which separates a correct rotation from one that is off by one or runs in the wrong direction. Random traffic with acks that come and go, occasional all-idle cycles and round starts exercises the state hold without ack and both ways the lock can clear. The random traffic is compared cycle by cycle against a reference model in the bench.

// File: rtl/arb_leaf_pkg.sv
package arb_leaf_pkg;
  localparam int unsigned NUM_IN = 4;
  localparam int unsigned SEL_W  = $clog2(NUM_IN);

  typedef logic [NUM_IN-1:0] vec_t;
  typedef logic [SEL_W-1:0]  sel_t;

  function automatic sel_t onehot_index(input vec_t oh);
    sel_t r;
    r = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (oh[i]) r = sel_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc
  import arb_leaf_pkg::*;
#(
  parameter int unsigned TOP = 3
) (
  input  vec_t req,
  output vec_t gnt
);
  logic found;
  sel_t idx;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      idx = sel_t'((TOP + NUM_IN - k) % NUM_IN);
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_round_lock.sv
module arb_round_lock
  import arb_leaf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t req,
  input  vec_t gnt,
  input  logic round_start,
  output logic lock
);
  vec_t served_q, served_d;
  logic lock_q, lock_d;
  logic upd_en;
  vec_t served_new;

  always_comb begin
    served_new = served_q | gnt;
    served_d   = served_q;
    lock_d     = lock_q;
    upd_en     = 1'b0;
    if (round_start || (req == '0)) begin
      served_d = '0;
      lock_d   = 1'b0;
      upd_en   = 1'b1;
    end else if (gnt != '0) begin
      served_d = served_new;
      lock_d   = lock_q | ((req & ~served_new) == '0);
      upd_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= '0;
      lock_q   <= 1'b0;
    end else if (upd_en) begin
      served_q <= served_d;
      lock_q   <= lock_d;
    end
  end

  assign lock = lock_q;

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    round_start |=> !lock_q);
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (!lock_q && served_q == '0));
  p_lock_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!round_start && req != '0 && gnt != '0 && ((req & ~(served_q | gnt)) == '0)) |=> lock_q);
endmodule

// File: rtl/arb_leaf.sv
module arb_leaf
  import arb_leaf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] req_i,
  input  logic       ack_i,
  input  logic       round_start_i,
  output logic [3:0] grant_o,
  output logic       up_req_o,
  output logic       lock_o
);
  logic rst_q_n;
  sel_t st_q, st_d;
  logic st_en;
  vec_t cand [NUM_IN];
  vec_t pick;
  vec_t eff_req;
  logic lock_w;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  // Each state s owns an encoder whose top priority is input (s+3) mod 4.
  for (genvar s = 0; s < NUM_IN; s++) begin : g_enc
    arb_prio_enc #(.TOP((s + NUM_IN - 1) % NUM_IN)) u_enc (
      .req(eff_req), .gnt(cand[s])
    );
  end

  assign eff_req = lock_w ? '0 : req_i;

  always_comb begin
    pick = cand[st_q];
  end

  assign grant_o  = ack_i ? pick : '0;
  assign up_req_o = (|req_i) && !lock_w;
  assign lock_o   = lock_w;

  always_comb begin
    st_en = (grant_o != '0);
    st_d  = onehot_index(grant_o);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  arb_round_lock u_lock (
    .clk(clk), .rst_n(rst_q_n), .req(req_i), .gnt(grant_o),
    .round_start(round_start_i), .lock(lock_w)
  );

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(grant_o));
  p_grant_in_req_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((grant_o & ~req_i) == '0));
  p_noack_quiet_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ack_i |-> (grant_o == '0));
  p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (grant_o == '0) |=> $stable(st_q));
  p_state_follow_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (grant_o != '0) |=> ((4'b0001 << st_q) == $past(grant_o)));
  p_upreq_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    up_req_o |-> (req_i != '0));
  p_locked_silent_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    lock_o |-> (grant_o == '0 && !up_req_o));
endmodule

// File: tb/arb_leaf_test.sv
`timescale 1ns/1ps
module arb_leaf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       ack = 1'b0;
  logic       rs = 1'b0;
  logic [3:0] grant;
  logic       up_req;
  logic       lock;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [1:0] m_st;
  logic [3:0] m_srv;
  logic       m_lock;

  arb_leaf uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack),
    .round_start_i(rs), .grant_o(grant), .up_req_o(up_req), .lock_o(lock)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] exp_pick(input logic [3:0] r, input logic [1:0] st);
    logic [3:0] g;
    int h;
    g = '0;
    h = (int'(st) + 3) % 4;
    for (int k = 0; k < 4; k++) begin
      int i;
      i = (h + 4 - k) % 4;
      if (g == '0 && r[i]) g[i] = 1'b1;
    end
    return g;
  endfunction

  function automatic logic [1:0] idx_of(input logic [3:0] g);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < 4; i++) if (g[i]) r = 2'(i);
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic a, input logic s,
                      input string tg, input string tu, input string tl);
    logic [3:0] eg;
    logic       eu;
    @(negedge clk);
    req = r; ack = a; rs = s;
    #2;
    eg = (a && !m_lock) ? exp_pick(r, m_st) : 4'b0;
    eu = (r != 0) && !m_lock;
    check(tg, "grant", grant, eg);
    check(tu, "up_req", {3'b0, up_req}, {3'b0, eu});
    check(tl, "lock", {3'b0, lock}, {3'b0, m_lock});
    if (s || r == 0) begin
      m_srv = '0; m_lock = 1'b0;
    end else if (eg != 0) begin
      m_srv = m_srv | eg;
      if ((r & ~m_srv) == 0) m_lock = 1'b1;
    end
    if (eg != 0) m_st = idx_of(eg);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd24680);
    m_st = '0; m_srv = '0; m_lock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state, then order 3,2,1,0 in state 00
    step(4'b0000, 1'b0, 1'b0, "R1", "R1", "R1");
    step(4'b1111, 1'b0, 1'b0, "R2", "R5", "R1");
    step(4'b0101, 1'b1, 1'b0, "R3", "R5", "R1");
    // R4: state now 10, input 0 ahead of 3 and 2
    step(4'b0101, 1'b1, 1'b0, "R4", "R5", "R6");
    // R6: locked, silent even with ack
    step(4'b0101, 1'b1, 1'b0, "R6", "R6", "R6");
    step(4'b0101, 1'b1, 1'b1, "R6", "R6", "R6");
    // R7: round start released the lock
    step(4'b0101, 1'b1, 1'b0, "R7", "R7", "R7");
    step(4'b0100, 1'b1, 1'b0, "R4", "R5", "R6");
    step(4'b0100, 1'b1, 1'b0, "R6", "R6", "R6");
    // R8: idle cycle clears the lock
    step(4'b0000, 1'b0, 1'b0, "R8", "R8", "R6");
    step(4'b0100, 1'b1, 1'b0, "R8", "R8", "R8");
    step(4'b0000, 1'b0, 1'b0, "R8", "R8", "R8");
    // R4: full sweep with saturated requests and round restarts
    for (int n = 0; n < 8; n++) begin
      step(4'b1111, 1'b1, 1'b1, "R4", "R5", "R7");
    end
    // R2/R3/R5/R6: random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      logic a, s;
      r = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) r = 4'b0;
      a = ($urandom_range(0, 3) != 0);
      s = ($urandom_range(0, 15) == 0);
      step(r, a, s, "R3", "R5", "R6");
    end
    finish_run();
  end
endmodule